// File: doc/BRIEF.md
# Addressed Multi-Drop SPI Target

This block is an SPI target (mode 0: SCLK idles low, data is sampled on rising SCLK edges and changes after falling edges) for a bus on which many targets share one active-low select line as well as SCLK, MOSI and MISO. Each select window begins with an address word that every target receives. A target whose configured address matches that word takes over the rest of the window. It enables its MISO driver, delivers each following received byte to the user logic and shifts out bytes the user supplies. Every other target leaves MISO undriven and ignores the bus until select goes high again.

The serial inputs are brought into the system clock domain through a two-flop synchronizer, and SCLK edges are detected there. SCLK must therefore run at no more than a quarter of the system clock; the bench uses one twelfth. MISO is presented as a data bit plus an output-enable for a tri-state pad, so a disabled enable means high impedance. On the user side, a received byte appears with a one-cycle valid pulse. A one-cycle take pulse marks the cycle in which the transmit byte input was captured.

Top module: `mspi_addr_target`

## Requirements
- R1: After reset, and no later than four system clock cycles after select goes high, `miso_oe` and `addressed` are low, so MISO is high impedance.
- R2: During the first 8 SCLK rising edges of a select window, `miso_oe` stays low and `miso_o` reads 1.
- R3: At the 8th rising SCLK edge, the received word (MSB first) is compared with `own_addr`. On a match, `addressed` and `miso_oe` go high and remain high until select rises.
- R4: On a mismatch, `miso_oe` stays low, and no `rx_valid` and no `tx_take` pulse occur for the rest of the window, whatever data follows.
- R5: For an addressed target, each complete 8-bit word after the address is sampled MSB first on rising SCLK edges. It is presented on `rx_data` with `rx_valid` high for exactly one cycle.
- R6: For an addressed target, `tx_data` is captured with a one-cycle `tx_take` pulse at the address match and at every later word boundary. The captured byte is sent MSB first, and its MSB is valid before the next rising SCLK edge.
- R7: When select rises in the middle of a word, the partial word produces no `rx_valid`. The next window starts again with an address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | WORD_W | Static address of this target |
| sclk_in | input | 1 | Serial clock from the bus master |
| sel_n_in | input | 1 | Shared active-low select |
| mosi_in | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data bit toward the master |
| miso_oe | output | 1 | Enable for the MISO pad driver; low means high impedance |
| tx_data | input | WORD_W | Next byte to transmit |
| tx_take | output | 1 | One-cycle pulse: `tx_data` was captured |
| rx_data | output | WORD_W | Last received data byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a new byte |
| addressed | output | 1 | High while this target owns the current window |

## Verification
The assertions check on every cycle that the MISO driver is released within four cycles of select going high. They also check that the valid and take strobes are single-cycle pulses, and that neither strobe ever occurs while the target is unaddressed. The bench's transfers are needed to show the things a property cannot see. These are whether the address comparison picks the right windows, whether received and transmitted bytes keep MSB-first order and word alignment, and whether MISO reads all ones with the driver off during the address phase. The bench also shows that a truncated word leaves no trace and that the next window starts cleanly.

// File: rtl/mspi_pkg.sv
package mspi_pkg;
  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DATA = 2'd1,
    PH_SKIP = 2'd2
  } phase_e;

  localparam int SYNC_W   = 3;
  localparam int IDX_SCLK = 0;
  localparam int IDX_SEL  = 1;
  localparam int IDX_MOSI = 2;
endpackage

// File: rtl/mspi_sync.sv
module mspi_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mspi_edge.sv
module mspi_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/mspi_engine.sv
module mspi_engine
  import mspi_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic [WORD_W-1:0] own_addr,
  input  logic [WORD_W-1:0] tx_data,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_take,
  output logic              matched,
  output logic              miso_bit
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  phase_e            phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] rx_sh;
  logic [WORD_W-1:0] tx_sh;
  logic              hold_shift;

  logic [WORD_W-1:0] rx_next;
  logic              word_done;

  assign rx_next   = {rx_sh[WORD_W-2:0], mosi_s};
  assign word_done = sclk_rise && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst || !sel_act) begin
      phase      <= PH_ADDR;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '1;
      rx_valid   <= 1'b0;
      tx_take    <= 1'b0;
      matched    <= 1'b0;
      hold_shift <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_take  <= 1'b0;
      if (sclk_rise) begin
        rx_sh   <= rx_next;
        bit_cnt <= word_done ? '0 : bit_cnt + 1'b1;
      end
      unique case (phase)
        PH_ADDR: begin
          if (word_done) begin
            if (rx_next == own_addr) begin
              phase      <= PH_DATA;
              matched    <= 1'b1;
              tx_sh      <= tx_data;
              tx_take    <= 1'b1;
              hold_shift <= 1'b1;
            end else begin
              phase <= PH_SKIP;
            end
          end
        end
        PH_DATA: begin
          if (word_done) begin
            rx_valid   <= 1'b1;
            tx_sh      <= tx_data;
            tx_take    <= 1'b1;
            hold_shift <= 1'b1;
          end else if (sclk_fall) begin
            if (hold_shift) hold_shift <= 1'b0;
            else            tx_sh      <= {tx_sh[WORD_W-2:0], 1'b1};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rx_data <= '0;
    else if (sel_act && phase == PH_DATA && word_done) rx_data <= rx_next;
  end

  assign miso_bit = matched ? tx_sh[WORD_W-1] : 1'b1;
endmodule

// File: rtl/mspi_addr_target.sv
module mspi_addr_target
  import mspi_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] own_addr,
  input  logic              sclk_in,
  input  logic              sel_n_in,
  input  logic              mosi_in,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_take,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              addressed
);
  localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << IDX_SEL;

  logic [SYNC_W-1:0] raw_in;
  logic [SYNC_W-1:0] sync_q;
  logic              sclk_rise, sclk_fall;
  logic              matched;

  always_comb begin
    raw_in           = '0;
    raw_in[IDX_SCLK] = sclk_in;
    raw_in[IDX_SEL]  = sel_n_in;
    raw_in[IDX_MOSI] = mosi_in;
  end

  mspi_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_in),
    .q  (sync_q)
  );

  mspi_edge u_sclk_edge (
    .clk (clk),
    .rst (rst),
    .lvl (sync_q[IDX_SCLK]),
    .rise(sclk_rise),
    .fall(sclk_fall)
  );

  mspi_engine #(.WORD_W(WORD_W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .sel_act  (~sync_q[IDX_SEL]),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .mosi_s   (sync_q[IDX_MOSI]),
    .own_addr (own_addr),
    .tx_data  (tx_data),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .tx_take  (tx_take),
    .matched  (matched),
    .miso_bit (miso_o)
  );

  assign miso_oe   = matched;
  assign addressed = matched;
endmodule

// File: rtl/mspi_addr_target_chk.sv
module mspi_addr_target_chk (
  input logic clk,
  input logic rst,
  input logic sel_n_in,
  input logic miso_oe,
  input logic addressed,
  input logic rx_valid,
  input logic tx_take
);
  logic [2:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                  hi_cnt <= '0;
    else if (!sel_n_in)       hi_cnt <= '0;
    else if (hi_cnt != 3'd4)  hi_cnt <= hi_cnt + 3'd1;
  end

  AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (rst) (hi_cnt == 3'd4) |-> (!miso_oe && !addressed)); // R1
  AST_RXV_PULSE: assert property (@(posedge clk) disable iff (rst) rx_valid |=> !rx_valid); // R5
  AST_RXV_ADDRESSED: assert property (@(posedge clk) disable iff (rst) rx_valid |-> addressed); // R4
  AST_TAKE_ADDRESSED: assert property (@(posedge clk) disable iff (rst) tx_take |-> addressed); // R6
  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (rst) tx_take |=> !tx_take); // R6
endmodule

bind mspi_addr_target mspi_addr_target_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_n_in (sel_n_in),
  .miso_oe  (miso_oe),
  .addressed(addressed),
  .rx_valid (rx_valid),
  .tx_take  (tx_take)
);

// File: tb/mspi_addr_target_tb_top.sv
module mspi_addr_target_tb_top;
  localparam int HALF = 6;
  localparam logic [7:0] MY_ADDR = 8'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sel_n = 1'b1, mosi = 1'b0;
  logic [7:0] tx_data;
  logic miso_o, miso_oe, tx_take, rx_valid, addressed;
  logic [7:0] rx_data;

  int checks = 0, fails = 0;
  int rx_cnt = 0, take_cnt = 0, cyc = 0;
  logic [7:0] rx_log [64];
  logic [7:0] dat [4];
  logic [7:0] got [4];

  always #5 clk = ~clk;

  mspi_addr_target dut_i (
    .clk(clk), .rst(rst), .own_addr(MY_ADDR),
    .sclk_in(sclk), .sel_n_in(sel_n), .mosi_in(mosi),
    .miso_o(miso_o), .miso_oe(miso_oe),
    .tx_data(tx_data), .tx_take(tx_take),
    .rx_data(rx_data), .rx_valid(rx_valid), .addressed(addressed)
  );

  function automatic logic [7:0] tx_pat(input int k);
    return 8'(k * 37 + 11);
  endfunction

  initial tx_data = tx_pat(0);

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        rx_log[rx_cnt % 64] = rx_data;
        rx_cnt++;
      end
      if (tx_take) begin
        take_cnt++;
        tx_data = tx_pat(take_cnt);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // nbits < 0 means the full transfer; otherwise select rises after nbits SCLK cycles
  task automatic xfer(input logic [7:0] addr, input int nbytes, input int nbits);
    int total, nb, rx0, tk0, exp_take, exp_rx, bad_oe;
    logic match;
    match = (addr == MY_ADDR);
    total = 8 + 8 * nbytes;
    nb = (nbits < 0) ? total : nbits;
    rx0 = rx_cnt; tk0 = take_cnt; bad_oe = 0;
    @(negedge clk) sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      int bi, bp;
      logic [7:0] w;
      bi = b / 8; bp = 7 - (b % 8);
      w = (bi == 0) ? addr : dat[bi-1];
      mosi = w[bp];
      repeat (HALF) @(negedge clk);
      if (bi == 0) begin
        if (miso_oe !== 1'b0 || miso_o !== 1'b1) begin
          bad_oe++;
          chk(1'b0, "R2 address phase oe/miso", {miso_oe, miso_o}, 2'b01);
        end
      end else begin
        if (miso_oe !== match) begin
          bad_oe++;
          chk(1'b0, match ? "R3 oe after match" : "R4 oe after mismatch", miso_oe, match);
        end
        if (match) got[bi-1][bp] = miso_o;
      end
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    chk(bad_oe == 0, "R2 R3 R4 oe during window", bad_oe, 0);
    repeat (HALF) @(negedge clk);
    sel_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(miso_oe == 1'b0 && addressed == 1'b0, "R1 R7 release after select", {miso_oe, addressed}, 0);
    exp_take = match ? nb / 8 : 0;
    exp_rx   = (match && nb >= 8) ? nb / 8 - 1 : 0;
    chk(take_cnt - tk0 == exp_take, match ? "R6 take count" : "R4 no take", take_cnt - tk0, exp_take);
    chk(rx_cnt - rx0 == exp_rx, (nb % 8 != 0) ? "R7 partial discarded" : (match ? "R5 rx count" : "R4 no rx"),
        rx_cnt - rx0, exp_rx);
    for (int j = 0; j < exp_rx; j++) begin
      chk(rx_log[(rx0 + j) % 64] == dat[j], "R5 rx byte", rx_log[(rx0 + j) % 64], dat[j]);
      chk(got[j] == tx_pat(tk0 + j), "R6 miso byte", got[j], tx_pat(tk0 + j));
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd7331);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(miso_oe == 1'b0 && addressed == 1'b0, "R1 reset state", {miso_oe, addressed}, 0);
    chk(rx_valid == 1'b0 && tx_take == 1'b0, "R1 reset strobes", {rx_valid, tx_take}, 0);

    // directed: matched, three bytes with edge patterns
    dat[0] = 8'h00; dat[1] = 8'hFF; dat[2] = 8'hA5;
    xfer(MY_ADDR, 3, -1);
    // directed: mismatch differing only in LSB, then in MSB
    xfer(MY_ADDR ^ 8'h01, 2, -1);
    xfer(MY_ADDR ^ 8'h80, 1, -1);
    // directed: select rises mid-byte, then a fresh window works (R7)
    dat[0] = 8'h3C; dat[1] = 8'hC3;
    xfer(MY_ADDR, 2, 8 + 8 + 3);
    xfer(MY_ADDR, 2, -1);
    // directed: select rises mid-address
    xfer(MY_ADDR, 1, 5);

    for (int t = 0; t < 20; t++) begin
      logic [7:0] a;
      int n;
      a = ($urandom % 3 == 0) ? 8'($urandom) : MY_ADDR;
      n = 1 + ($urandom % 4);
      for (int k = 0; k < 4; k++) dat[k] = 8'($urandom);
      xfer(a, n, -1);
    end
    finish_run();
  end
endmodule